// File: doc/BRIEF.md
# Modem Handshake Status Tracker

This block watches four active-low modem handshake pins (clear-to-send, data-set-ready, ring indicator and carrier detect). It presents an 8-bit status byte to a host bus. The upper nibble gives the present line levels as active-high values. The lower nibble holds sticky change flags that the host clears by reading the byte. The clear-to-send, data-set-ready and carrier-detect flags record a change in either direction. The ring flag records only the moment the ring indication ends, which is the pin returning from low to high.

The block also has an internal loopback mode used for self-test. In this mode the external pins are ignored. The four status sources are taken from the block's own modem-control outputs: RTS drives the clear-to-send slot, DTR drives the data-set-ready slot, OUT1 drives the ring slot and OUT2 drives the carrier slot. Change flags and the interrupt then come from those control bits. The modem-status interrupt request is the OR of the four change flags, gated by a single enable input.

External pins pass through a two-stage synchronizer. Change detection is held off until that pipeline has filled after reset, so reset never produces a false change.

Top module: `mdm_status`

## Requirements
- R1: Outside loopback, status bits 4, 5, 6 and 7 equal the inverse of cts_n, dsr_n, ri_n and dcd_n respectively. The value is visible two clock edges after the pin changes.
- R2: Outside loopback, a change in either direction on cts_n, dsr_n or dcd_n sets status bit 0, 1 or 3 respectively. The flag is visible three clock edges after the pin changes.
- R3: Status bit 2 sets only when ri_n goes from 0 to 1. A 1-to-0 transition of ri_n leaves bit 2 unchanged.
- R4: A change flag stays set until a read. When rd_stb is high for a cycle, stat shows the flags as they were before the clear. After that clock edge, bits 0 to 3 are cleared.
- R5: If a change is detected on the same edge that ends a read, its flag is left set after the clear.
- R6: With loop_en high, status bits 4, 5, 6 and 7 equal ctl_rts, ctl_dtr, ctl_out1 and ctl_out2 in the same cycle. The external pins have no effect on stat.
- R7: With loop_en high, bits 0, 1 and 3 set one edge after ctl_rts, ctl_dtr or ctl_out2 changes. Bit 2 sets one edge after ctl_out1 falls from 1 to 0.
- R8: irq is high exactly when irq_en is high and at least one of status bits 0 to 3 is set.
- R9: After reset, bits 0 to 3 are 0. No change flag sets as a result of the synchronizer filling, whatever the pins held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en | input | 1 | Internal loopback select |
| ctl_dtr | input | 1 | DTR control output, source of bit 5 in loopback |
| ctl_rts | input | 1 | RTS control output, source of bit 4 in loopback |
| ctl_out1 | input | 1 | OUT1 control output, source of bit 6 in loopback |
| ctl_out2 | input | 1 | OUT2 control output, source of bit 7 in loopback |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Host read strobe for the status byte |
| stat | output | 8 | Status byte: change flags [3:0], levels [7:4] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A pin change reaches the level bits after two edges and the change flag after three edges. A control-bit change in loopback reaches the level bits in the same cycle and the flag after one edge. A read clears the flags on the edge that closes the read cycle, and irq follows the flags with no added delay. The bench drives inputs just after a falling edge. At each falling edge it first advances its own model by the rising edge that has just passed, then compares stat and irq. Every result is therefore sampled half a period after the edge that produces it. Directed cases wait the exact number of edges given above before their fixed-value checks.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINE  = 4;
  // slot order inside a line vector: 0 clear-to-send, 1 data-set-ready,
  // 2 ring, 3 carrier
  localparam int CTS_IX = 0;
  localparam int DSR_IX = 1;
  localparam int RI_IX  = 2;
  localparam int DCD_IX = 3;

  typedef logic [NLINE-1:0] lvl_t;

  // active-high level of each slot from the chosen source
  function automatic lvl_t pick_src(logic loop, lvl_t pins_n, lvl_t ctl);
    return loop ? ctl : ~pins_n;
  endfunction

  // change events: any toggle, except the ring slot which reports
  // only the end of a ring (active level falling)
  function automatic lvl_t find_evt(lvl_t now, lvl_t prv);
    lvl_t e;
    e = now ^ prv;
    e[RI_IX] = prv[RI_IX] & ~now[RI_IX];
    return e;
  endfunction

  // next value of the sticky flags
  function automatic lvl_t next_flags(lvl_t cur, lvl_t evt, logic rd);
    return rd ? evt : (cur | evt);
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= '1;
          else        pipe[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[i] <= '1;
          else        pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

  logic warm_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;

  // R1
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> (pipe[0] == $past(din)));
endmodule

// File: rtl/mdm_lvl_src.sv
module mdm_lvl_src
  import mdm_pkg::*;
(
  input  logic loop_en,
  input  lvl_t pins_sync_n,
  input  logic ctl_dtr,
  input  logic ctl_rts,
  input  logic ctl_out1,
  input  logic ctl_out2,
  output lvl_t src
);
  lvl_t ctl_map;

  always_comb begin
    ctl_map         = '0;
    ctl_map[CTS_IX] = ctl_rts;
    ctl_map[DSR_IX] = ctl_dtr;
    ctl_map[RI_IX]  = ctl_out1;
    ctl_map[DCD_IX] = ctl_out2;
    src             = pick_src(loop_en, pins_sync_n, ctl_map);
  end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_t src,
  input  logic rd_stb,
  output lvl_t flg_o,
  output lvl_t evt_o
);
  localparam int ARM_MAX = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_MAX + 1);

  lvl_t             prv_q;
  lvl_t             flg_q;
  logic [ARM_W-1:0] arm_q;
  logic             armed;
  lvl_t             evt;

  assign armed = (arm_q == ARM_W'(ARM_MAX));
  assign evt   = armed ? find_evt(src, prv_q) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prv_q <= '0;
      flg_q <= '0;
      arm_q <= '0;
    end else begin
      prv_q <= src;
      flg_q <= next_flags(flg_q, evt, rd_stb);
      if (!armed) arm_q <= arm_q + 1'b1;
    end

  assign flg_o = flg_q;
  assign evt_o = evt;

  // R4
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((flg_q & $past(flg_q)) == $past(flg_q)));
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((flg_q & ~$past(evt)) == '0));
  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((flg_q & $past(evt)) == $past(evt)));
  // R3
  ri_end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[RI_IX]) |-> ($past(prv_q[RI_IX]) && !$past(src[RI_IX])));
  // R2
  cts_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[CTS_IX]) |-> ($past(prv_q[CTS_IX]) != $past(src[CTS_IX])));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       loop_en,
  input  logic       ctl_dtr,
  input  logic       ctl_rts,
  input  logic       ctl_out1,
  input  logic       ctl_out2,
  input  logic       irq_en,
  input  logic       rd_stb,
  output logic [7:0] stat,
  output logic       irq
);
  lvl_t pins_n;
  lvl_t pins_sync_n;
  lvl_t src;
  lvl_t flg;
  lvl_t evt;

  always_comb begin
    pins_n         = '1;
    pins_n[CTS_IX] = cts_n;
    pins_n[DSR_IX] = dsr_n;
    pins_n[RI_IX]  = ri_n;
    pins_n[DCD_IX] = dcd_n;
  end

  mdm_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_n),
    .dout (pins_sync_n)
  );

  mdm_lvl_src u_src (
    .loop_en    (loop_en),
    .pins_sync_n(pins_sync_n),
    .ctl_dtr    (ctl_dtr),
    .ctl_rts    (ctl_rts),
    .ctl_out1   (ctl_out1),
    .ctl_out2   (ctl_out2),
    .src        (src)
  );

  mdm_delta #(.SYNC_STAGES(SYNC_STAGES)) u_delta (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (src),
    .rd_stb(rd_stb),
    .flg_o(flg),
    .evt_o(evt)
  );

  assign stat = {src, flg};
  assign irq  = irq_en & (|flg);

  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R8
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (stat[3:0] != 4'h0)) |-> irq);
  // R7
  loop_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && $past(loop_en) && (ctl_rts != $past(ctl_rts))) |-> (evt[CTS_IX] || $past(!rst_n)));
endmodule

// File: tb/mdm_status_tb_top.sv
module mdm_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       loop_en = 1'b0;
  logic       ctl_dtr = 1'b0, ctl_rts = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
  logic       irq_en = 1'b0, rd_stb = 1'b0;
  logic [7:0] stat;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mdm_status dut_i (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .loop_en(loop_en), .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
    .ctl_out1(ctl_out1), .ctl_out2(ctl_out2), .irq_en(irq_en),
    .rd_stb(rd_stb), .stat(stat), .irq(irq)
  );

  // reference state, slot order: 0 cts, 1 dsr, 2 ri, 3 dcd
  logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_prv = 4'h0, m_flg = 4'h0;
  int         m_arm = 0;

  function automatic logic [3:0] raw_pins();
    return {dcd_n, ri_n, dsr_n, cts_n};
  endfunction

  function automatic logic [3:0] m_src(logic [3:0] s2);
    if (loop_en) return {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};
    return ~s2;
  endfunction

  function automatic logic [3:0] m_evt(logic [3:0] now, logic [3:0] old);
    logic [3:0] e;
    e    = now ^ old;
    e[2] = old[2] & ~now[2];
    return e;
  endfunction

  task automatic m_advance();
    logic [3:0] s, e;
    if (!rst_n) begin
      m_s1 = 4'hF; m_s2 = 4'hF; m_prv = 4'h0; m_flg = 4'h0; m_arm = 0;
      return;
    end
    s = m_src(m_s2);
    e = (m_arm == 3) ? m_evt(s, m_prv) : 4'h0;
    m_flg = rd_stb ? e : (m_flg | e);
    m_prv = s;
    m_s2  = m_s1;
    m_s1  = raw_pins();
    if (m_arm < 3) m_arm++;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    logic [3:0] lv;
    lv = m_src(m_s2);
    if (loop_en) check("R6 levels", {4'h0, stat[7:4]}, {4'h0, lv});
    else         check("R1 levels", {4'h0, stat[7:4]}, {4'h0, lv});
    if (loop_en) check("R7 flags", {4'h0, stat[3:0]}, {4'h0, m_flg});
    else begin
      check("R2 flags", {4'h0, stat[3:0] & 4'hB}, {4'h0, m_flg & 4'hB});
      check("R3 ring flag", {7'h0, stat[2]}, {7'h0, m_flg[2]});
    end
    check("R8 irq", {7'h0, irq}, {7'h0, irq_en & (|m_flg)});
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_advance();
      cmp_model();
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R9: pins held active through reset
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0;
    step(3);
    rst_n = 1'b1;
    step(6);
    check("R9 no flags after reset", {4'h0, stat[3:0]}, 8'h00);
    check("R1 levels after reset", {4'h0, stat[7:4]}, 8'h0F);

    // R3: ri_n 0 -> 1 sets bit 2; 1 -> 0 does not
    irq_en = 1'b1;
    ri_n = 1'b1;
    step(2);
    check("R1 ring level after 2 edges", {7'h0, stat[6]}, 8'h00);
    check("R3 not yet at 2 edges", {7'h0, stat[2]}, 8'h00);
    step(1);
    check("R3 ring end flag", {7'h0, stat[2]}, 8'h01);
    check("R8 irq on flag", {7'h0, irq}, 8'h01);
    rd_stb = 1'b1;
    step(1);
    // R4: flags cleared after the read edge
    check("R4 cleared", {4'h0, stat[3:0]}, 8'h00);
    rd_stb = 1'b0;
    ri_n = 1'b0;
    step(4);
    check("R3 ring start ignored", {4'h0, stat[3:0]}, 8'h00);

    // R2: carrier toggle, three edges
    dcd_n = 1'b1;
    step(3);
    check("R2 carrier flag", {4'h0, stat[3:0]}, 8'h08);
    irq_en = 1'b0;
    step(1);
    check("R8 irq gated", {7'h0, irq}, 8'h00);
    irq_en = 1'b1;

    // R4: read shows pre-clear value during the read cycle
    rd_stb = 1'b1;
    check("R4 read data before clear", {4'h0, stat[3:0]}, 8'h08);
    step(1);
    rd_stb = 1'b0;

    // R6 / R7 / R5: loopback
    loop_en = 1'b1;
    ctl_rts = 1'b1; ctl_dtr = 1'b0; ctl_out1 = 1'b1; ctl_out2 = 1'b0;
    #0;
    check("R6 loop levels same cycle", {4'h0, stat[7:4]}, 8'h05);
    step(1);
    rd_stb = 1'b1;
    step(1);
    check("R4 loop clear", {4'h0, stat[3:0]}, 8'h00);
    ctl_rts = 1'b0;
    step(1);
    check("R5 change wins over clear", {4'h0, stat[3:0]}, 8'h01);
    rd_stb = 1'b0;
    ctl_out1 = 1'b0;
    step(1);
    check("R7 out1 fall sets ring flag", {4'h0, stat[3:0]}, 8'h05);
    cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b0;
    step(4);
    check("R6 pins ignored in loopback", {4'h0, stat[3:0]}, 8'h05);
    check("R6 loop levels unchanged", {4'h0, stat[7:4]}, 8'h00);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) cts_n = ~cts_n;
      if ($urandom_range(7) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(7) == 0) ri_n  = ~ri_n;
      if ($urandom_range(7) == 0) dcd_n = ~dcd_n;
      if ($urandom_range(7) == 0) ctl_rts  = ~ctl_rts;
      if ($urandom_range(7) == 0) ctl_dtr  = ~ctl_dtr;
      if ($urandom_range(7) == 0) ctl_out1 = ~ctl_out1;
      if ($urandom_range(7) == 0) ctl_out2 = ~ctl_out2;
      if ($urandom_range(63) == 0) loop_en = ~loop_en;
      if ($urandom_range(15) == 0) irq_en = ~irq_en;
      rd_stb = ($urandom_range(3) == 0);
      step(1);
    end
    summary();
  end
endmodule